// File: doc/BRIEF.md
# Data Pointer and Register Exchange Unit

This block is the nibble datapath that sits beside the sequencer of a small 4-bit controller. It holds an 8-bit data pointer made of a high nibble and a low nibble, the accumulator, a zero flag, four working nibbles and two save nibbles for each half of the pointer. Each accepted operation byte is decoded and executed in one clock edge. The operations are pointer loads, low-nibble step up and step down, transfers between the accumulator and the low nibble, and two-way swaps.

Operation bytes arrive on a valid/ready stream. The unit never applies back-pressure, so `op_ready` is always high. A byte is consumed on every rising edge where `op_valid` is high, and its effect shows on the outputs right after that edge. A sender may hold `op_valid` high on consecutive cycles to issue back-to-back operations, and it may drop `op_valid` at any time. While `op_valid` is low, the value on `op_code` is ignored. Every register is visible on the output ports.

Top module: `dpx_unit`

## Requirements
- R1: A byte `1000_iiii` sets the pointer high nibble to 0000 and the pointer low nibble to `iiii`.
- R2: A byte `0100_iiii` sets the pointer high nibble to `iiii` and leaves the low nibble unchanged.
- R3: Byte `1111_1100` adds one to the pointer low nibble, wrapping 1111 to 0000, and sets the zero flag exactly when the new nibble is 0000.
- R4: Byte `1111_1101` subtracts one from the pointer low nibble, wrapping 0000 to 1111, and sets the zero flag exactly when the new nibble is 0000.
- R5: Byte `1111_1110` copies the accumulator into the pointer low nibble and leaves the zero flag unchanged.
- R6: Byte `1111_0000` copies the pointer low nibble into the accumulator and sets the zero flag exactly when the copied value is 0000.
- R7: Byte `0010_0011` swaps the accumulator and the pointer high nibble, using the old value of each.
- R8: Byte `1110_10tt` swaps the accumulator with working register `tt`, read as a binary index (00 selects register 0 and 11 selects register 3). All other working registers keep their values.
- R9: Byte `1110_010a` swaps the pointer high nibble with high save register `a`. Byte `1110_011a` swaps the pointer low nibble with low save register `a`.
- R10: An operation takes effect only on an edge where `op_valid` is high. `op_ready` is always 1. With `op_valid` low, no register and no flag change, whatever `op_code` holds.
- R11: A byte that matches none of the patterns above changes no register and no flag.
- R12: While `rst_n` is low, every register and the zero flag are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low reset, applied synchronously |
| op_valid | input | 1 | Operation byte present |
| op_ready | output | 1 | Always 1; the unit accepts a byte every cycle |
| op_code | input | 8 | Operation byte |
| ptr_hi_o | output | 4 | Pointer high nibble |
| ptr_lo_o | output | 4 | Pointer low nibble |
| acc_o | output | 4 | Accumulator |
| zero_o | output | 1 | Zero flag |
| work_o | output | NUM_WR*4 | Working registers; register k is at bits [4k+3:4k] |
| hsave_o | output | NUM_SAVE*4 | High save registers; register k is at bits [4k+3:4k] |
| lsave_o | output | NUM_SAVE*4 | Low save registers; register k is at bits [4k+3:4k] |

## Verification
The bench builds the unit with its default parameters, NUM_WR = 4 and NUM_SAVE = 2. With those values every code of the 2-bit working-register select and both codes of the save select reach a real register. That lets the bench confirm that each swap touches only the addressed register. The runs also drive the low nibble through its wrap points in both directions, check the zero flag across transfers that must leave it alone, and issue bytes that match no pattern.

// File: rtl/dpx_pkg.sv
package dpx_pkg;
  localparam int NIB_W = 4;
  localparam int OPC_W = 2 * NIB_W;
  localparam int SEL_W = 2;

  typedef enum logic [3:0] {
    K_NOP, K_LDZ, K_LHI, K_INC, K_DEC, K_A2L, K_L2A, K_XAH, K_XAW, K_XHS, K_XLS
  } kind_e;
endpackage

// File: rtl/dpx_decode.sv
module dpx_decode
  import dpx_pkg::*;
(
  input  logic             vld,
  input  logic [OPC_W-1:0] opc,
  output kind_e            kind,
  output logic [NIB_W-1:0] imm,
  output logic [SEL_W-1:0] sel
);
  always_comb begin
    imm  = opc[NIB_W-1:0];
    sel  = opc[SEL_W-1:0];
    kind = K_NOP;
    if (vld) begin
      casez (opc)
        8'b1000_????: kind = K_LDZ;
        8'b0100_????: kind = K_LHI;
        8'b1111_1100: kind = K_INC;
        8'b1111_1101: kind = K_DEC;
        8'b1111_1110: kind = K_A2L;
        8'b1111_0000: kind = K_L2A;
        8'b0010_0011: kind = K_XAH;
        8'b1110_10??: kind = K_XAW;
        8'b1110_010?: kind = K_XHS;
        8'b1110_011?: kind = K_XLS;
        default:      kind = K_NOP;
      endcase
    end
  end
endmodule

// File: rtl/dpx_bank.sv
module dpx_bank
  import dpx_pkg::*;
#(
  parameter int NUM_WR   = 4,
  parameter int NUM_SAVE = 2
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  kind_e                          kind,
  input  logic [SEL_W-1:0]               sel,
  input  logic [NIB_W-1:0]               acc,
  input  logic [NIB_W-1:0]               dph,
  input  logic [NIB_W-1:0]               dpl,
  output logic [NUM_WR-1:0][NIB_W-1:0]   wr_q,
  output logic [NUM_SAVE-1:0][NIB_W-1:0] hs_q,
  output logic [NUM_SAVE-1:0][NIB_W-1:0] ls_q,
  output logic [NIB_W-1:0]               wr_sel,
  output logic [NIB_W-1:0]               hs_sel,
  output logic [NIB_W-1:0]               ls_sel
);
  localparam int WSEL_W = $clog2(NUM_WR);
  localparam int SSEL_W = $clog2(NUM_SAVE);

  logic [WSEL_W-1:0] widx;
  logic [SSEL_W-1:0] sidx;

  assign widx   = sel[WSEL_W-1:0];
  assign sidx   = sel[SSEL_W-1:0];
  assign wr_sel = wr_q[widx];
  assign hs_sel = hs_q[sidx];
  assign ls_sel = ls_q[sidx];

  for (genvar g = 0; g < NUM_WR; g++) begin : g_wr
    always_ff @(posedge clk) begin
      if (!rst_n)                                         wr_q[g] <= '0;
      else if (kind == K_XAW && widx == WSEL_W'(g))       wr_q[g] <= acc;
    end

    AST_WR_TAKES_ACC: assert property (@(posedge clk) disable iff (!rst_n)
      (kind == K_XAW && widx == WSEL_W'(g)) |=> wr_q[g] == $past(acc)); // R8
    AST_WR_OTHERS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (kind == K_XAW && widx != WSEL_W'(g)) |=> $stable(wr_q[g])); // R8
  end

  for (genvar g = 0; g < NUM_SAVE; g++) begin : g_sv
    always_ff @(posedge clk) begin
      if (!rst_n)                                         hs_q[g] <= '0;
      else if (kind == K_XHS && sidx == SSEL_W'(g))       hs_q[g] <= dph;
    end
    always_ff @(posedge clk) begin
      if (!rst_n)                                         ls_q[g] <= '0;
      else if (kind == K_XLS && sidx == SSEL_W'(g))       ls_q[g] <= dpl;
    end

    AST_HS_TAKES_PTR: assert property (@(posedge clk) disable iff (!rst_n)
      (kind == K_XHS && sidx == SSEL_W'(g)) |=> hs_q[g] == $past(dph)); // R9
    AST_LS_TAKES_PTR: assert property (@(posedge clk) disable iff (!rst_n)
      (kind == K_XLS && sidx == SSEL_W'(g)) |=> ls_q[g] == $past(dpl)); // R9
  end
endmodule

// File: rtl/dpx_ptr.sv
module dpx_ptr
  import dpx_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  kind_e            kind,
  input  logic [NIB_W-1:0] imm,
  input  logic [NIB_W-1:0] wr_sel,
  input  logic [NIB_W-1:0] hs_sel,
  input  logic [NIB_W-1:0] ls_sel,
  output logic [NIB_W-1:0] dph_q,
  output logic [NIB_W-1:0] dpl_q,
  output logic [NIB_W-1:0] acc_q,
  output logic             zf_q
);
  logic [NIB_W-1:0] inc_v, dec_v;

  assign inc_v = dpl_q + NIB_W'(1);
  assign dec_v = dpl_q - NIB_W'(1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dph_q <= '0;
      dpl_q <= '0;
      acc_q <= '0;
      zf_q  <= 1'b0;
    end else begin
      case (kind)
        K_LDZ: begin dph_q <= '0; dpl_q <= imm; end
        K_LHI: dph_q <= imm;
        K_INC: begin dpl_q <= inc_v; zf_q <= (inc_v == '0); end
        K_DEC: begin dpl_q <= dec_v; zf_q <= (dec_v == '0); end
        K_A2L: dpl_q <= acc_q;
        K_L2A: begin acc_q <= dpl_q; zf_q <= (dpl_q == '0); end
        K_XAH: begin acc_q <= dph_q; dph_q <= acc_q; end
        K_XAW: acc_q <= wr_sel;
        K_XHS: dph_q <= hs_sel;
        K_XLS: dpl_q <= ls_sel;
        default: ;
      endcase
    end
  end

  AST_LDZ_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    kind == K_LDZ |=> dph_q == '0 && dpl_q == $past(imm)); // R1
  AST_LHI_KEEPS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    kind == K_LHI |=> dph_q == $past(imm) && $stable(dpl_q)); // R2
  AST_INC_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    kind == K_INC |=> dpl_q == $past(dpl_q) + NIB_W'(1) && zf_q == (dpl_q == '0)); // R3
  AST_DEC_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    kind == K_DEC |=> dpl_q == $past(dpl_q) - NIB_W'(1) && zf_q == (dpl_q == '0)); // R4
  AST_A2L_FLAG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    kind == K_A2L |=> $stable(zf_q) && dpl_q == $past(acc_q)); // R5
  AST_L2A_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    kind == K_L2A |=> acc_q == $past(dpl_q) && zf_q == (acc_q == '0)); // R6
  AST_XAH_SWAP: assert property (@(posedge clk) disable iff (!rst_n)
    kind == K_XAH |=> acc_q == $past(dph_q) && dph_q == $past(acc_q)); // R7
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    kind == K_NOP |=> $stable(dph_q) && $stable(dpl_q) && $stable(acc_q) && $stable(zf_q)); // R10
endmodule

// File: rtl/dpx_unit.sv
module dpx_unit
  import dpx_pkg::*;
#(
  parameter int NUM_WR   = 4,
  parameter int NUM_SAVE = 2
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      op_valid,
  output logic                      op_ready,
  input  logic [OPC_W-1:0]          op_code,
  output logic [NIB_W-1:0]          ptr_hi_o,
  output logic [NIB_W-1:0]          ptr_lo_o,
  output logic [NIB_W-1:0]          acc_o,
  output logic                      zero_o,
  output logic [NUM_WR*NIB_W-1:0]   work_o,
  output logic [NUM_SAVE*NIB_W-1:0] hsave_o,
  output logic [NUM_SAVE*NIB_W-1:0] lsave_o
);
  kind_e                           kind;
  logic [NIB_W-1:0]                imm;
  logic [SEL_W-1:0]                sel;
  logic [NUM_WR-1:0][NIB_W-1:0]    wr_q;
  logic [NUM_SAVE-1:0][NIB_W-1:0]  hs_q, ls_q;
  logic [NIB_W-1:0]                wr_sel, hs_sel, ls_sel;

  assign op_ready = 1'b1;

  dpx_decode u_dec (
    .vld  (op_valid & op_ready),
    .opc  (op_code),
    .kind (kind),
    .imm  (imm),
    .sel  (sel)
  );

  dpx_ptr u_ptr (
    .clk    (clk),
    .rst_n  (rst_n),
    .kind   (kind),
    .imm    (imm),
    .wr_sel (wr_sel),
    .hs_sel (hs_sel),
    .ls_sel (ls_sel),
    .dph_q  (ptr_hi_o),
    .dpl_q  (ptr_lo_o),
    .acc_q  (acc_o),
    .zf_q   (zero_o)
  );

  dpx_bank #(.NUM_WR(NUM_WR), .NUM_SAVE(NUM_SAVE)) u_bank (
    .clk    (clk),
    .rst_n  (rst_n),
    .kind   (kind),
    .sel    (sel),
    .acc    (acc_o),
    .dph    (ptr_hi_o),
    .dpl    (ptr_lo_o),
    .wr_q   (wr_q),
    .hs_q   (hs_q),
    .ls_q   (ls_q),
    .wr_sel (wr_sel),
    .hs_sel (hs_sel),
    .ls_sel (ls_sel)
  );

  assign work_o  = wr_q;
  assign hsave_o = hs_q;
  assign lsave_o = ls_q;

  AST_XAW_ACC: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_code[7:2] == 6'b1110_10) |=> acc_o == $past(wr_sel)); // R8
  AST_XLS_PTR: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_code[7:1] == 7'b1110_011) |=> ptr_lo_o == $past(ls_sel)); // R9
endmodule

// File: tb/dpx_unit_tb_top.sv
module dpx_unit_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       op_valid = 1'b0;
  logic       op_ready;
  logic [7:0] op_code = 8'h00;
  logic [3:0] ptr_hi_o, ptr_lo_o, acc_o;
  logic       zero_o;
  logic [15:0] work_o;
  logic [7:0]  hsave_o, lsave_o;

  always #5 clk = ~clk;

  dpx_unit dut_i (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_ready(op_ready),
    .op_code(op_code), .ptr_hi_o(ptr_hi_o), .ptr_lo_o(ptr_lo_o), .acc_o(acc_o),
    .zero_o(zero_o), .work_o(work_o), .hsave_o(hsave_o), .lsave_o(lsave_o)
  );

  typedef struct { logic [44:0] v; string tag; } exp_t;
  exp_t q[$];
  int n_run = 0, n_fail = 0;
  logic done = 1'b0;

  logic [3:0]  m_dph, m_dpl, m_acc;
  logic        m_zf;
  logic [15:0] m_a;
  logic [7:0]  m_h, m_l;

  function automatic logic [44:0] model_vec();
    return {m_dph, m_dpl, m_acc, m_zf, m_a, m_h, m_l};
  endfunction

  function automatic logic [44:0] dut_vec();
    return {ptr_hi_o, ptr_lo_o, acc_o, zero_o, work_o, hsave_o, lsave_o};
  endfunction

  task automatic model_clear();
    m_dph = 0; m_dpl = 0; m_acc = 0; m_zf = 0; m_a = 0; m_h = 0; m_l = 0;
  endtask

  task automatic model_apply(input logic [7:0] op);
    logic [3:0] t;
    int i;
    i = int'(op[1:0]);
    casez (op)
      8'b1000_????: begin m_dph = 0; m_dpl = op[3:0]; end
      8'b0100_????: m_dph = op[3:0];
      8'b1111_1100: begin m_dpl = m_dpl + 4'd1; m_zf = (m_dpl == 0); end
      8'b1111_1101: begin m_dpl = m_dpl - 4'd1; m_zf = (m_dpl == 0); end
      8'b1111_1110: m_dpl = m_acc;
      8'b1111_0000: begin m_acc = m_dpl; m_zf = (m_dpl == 0); end
      8'b0010_0011: begin t = m_acc; m_acc = m_dph; m_dph = t; end
      8'b1110_10??: begin t = m_a[i*4 +: 4]; m_a[i*4 +: 4] = m_acc; m_acc = t; end
      8'b1110_010?: begin i = int'(op[0]); t = m_h[i*4 +: 4]; m_h[i*4 +: 4] = m_dph; m_dph = t; end
      8'b1110_011?: begin i = int'(op[0]); t = m_l[i*4 +: 4]; m_l[i*4 +: 4] = m_dpl; m_dpl = t; end
      default: ;
    endcase
  endtask

  task automatic compare(input logic [44:0] act, input logic [44:0] exp, input string tag);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // driver: one byte per call, back-to-back when called repeatedly
  task automatic send(input logic [7:0] op, input string tag);
    exp_t e;
    @(negedge clk);
    op_code  = op;
    op_valid = 1'b1;
    model_apply(op);
    e.v = model_vec();
    e.tag = tag;
    q.push_back(e);
  endtask

  task automatic idle(input int n, input logic [7:0] op);
    @(negedge clk);
    op_valid = 1'b0;
    op_code  = op;
    repeat (n) @(negedge clk);
  endtask

  // monitor: pops the expected state for every accepted byte
  initial begin
    forever begin
      @(posedge clk);
      if (op_valid === 1'b1 && rst_n === 1'b1) begin
        exp_t e;
        #2;
        if (q.size() == 0) begin
          n_run++; n_fail++;
          $display("FAIL R10: actual result with empty queue, expected none");
        end else begin
          e = q.pop_front();
          compare(dut_vec(), e.v, e.tag);
        end
      end
    end
  end

  initial begin
    #(10 * 5000);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: actual timeout, expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    model_clear();
    repeat (3) @(negedge clk);
    compare(dut_vec(), 45'd0, "R12 reset state");
    rst_n = 1'b1;

    send(8'h8A, "R1 load zero/low");
    send(8'h45, "R2 load high");
    send(8'h8F, "R1 load low F");
    send(8'hFC, "R3 inc wrap to zero");
    send(8'hFC, "R3 inc to one");
    send(8'hFD, "R4 dec to zero");
    send(8'hFD, "R4 dec wrap to F");
    send(8'hF0, "R6 low to acc nonzero");
    send(8'h80, "R1 load low 0");
    send(8'hF0, "R6 low to acc zero");
    send(8'h87, "R1 load low 7");
    send(8'hFE, "R5 acc to low keeps flag set");
    send(8'h83, "R1 load low 3");
    send(8'hF0, "R6 acc=3");
    send(8'h49, "R2 high=9");
    send(8'hFE, "R5 acc to low keeps flag clear");
    send(8'h23, "R7 swap acc/high");
    for (int t = 0; t < 4; t++) begin
      send(8'h81 + 8'(t), "R1 setup");
      send(8'hF0, "R6 setup");
      send(8'hE8 | 8'(t), "R8 swap acc/work");
    end
    send(8'hEA, "R8 swap work 2 again");
    send(8'h4C, "R2 high=C");
    send(8'hE4, "R9 swap high/save0");
    send(8'h4D, "R2 high=D");
    send(8'hE5, "R9 swap high/save1");
    send(8'h86, "R1 low=6");
    send(8'hE6, "R9 swap low/save0");
    send(8'h8B, "R1 low=B");
    send(8'hE7, "R9 swap low/save1");
    send(8'hE7, "R9 swap low/save1 back");
    send(8'h00, "R11 undefined 00");
    send(8'hFF, "R11 undefined FF");
    send(8'h12, "R11 undefined 12");
    send(8'hE0, "R11 undefined E0");
    send(8'h22, "R11 undefined 22");
    idle(4, 8'hFC);
    compare(dut_vec(), model_vec(), "R10 idle with opcode present");
    n_run++;
    if (op_ready !== 1'b1) begin
      n_fail++;
      $display("FAIL R10: actual ready %b expected 1", op_ready);
    end
    rst_n = 1'b0;
    model_clear();
    @(negedge clk);
    compare(dut_vec(), 45'd0, "R12 reset after activity");
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule